// File: doc/BRIEF.md
# PHY Link Monitor with Polling Sequencer and Change Interrupt

This block watches the link state of a group of Ethernet ports. A polling sequencer walks a contiguous window of PHY addresses and, for each, issues a request to an external management-bus engine. The engine answers with a compact status nibble holding link, duplex and speed. The block keeps one status word per port. When a newly polled link bit differs from the stored one, it latches a change flag for that port.

Software reaches the block through a small word-indexed register port. The port status words can only be read. The change flags are cleared by writing ones. A mask register holds one bit per port, and a set bit blocks that port from the interrupt. A carrier output tells whether any port below the CPU port has link. The preamble and clock-divider fields of the polling configuration go straight out to the management-bus engine.

Top module: `phy_link_monitor`

## Requirements
- R1: After reset, all port status words, the change flags and the polling configuration read 0. The mask reads 0x7f. `poll_req`, `irq` and `carrier_up` are low.
- R2: The polling configuration sits at index 8. Bit 31 is the enable, bit 30 the preamble flag, bits 29:24 the clock divider, bits 12:8 the highest address and bits 4:0 the lowest address. All other bits read 0. The preamble flag drives `poll_preamble` and the divider drives `poll_clk_div`.
- R3: While polling, requests visit the addresses from lowest to highest in ascending order and then wrap back to lowest. Each request holds `poll_addr` steady until `poll_ack`.
- R4: No new request starts while the enable bit is 0 or the lowest address is greater than the highest.
- R5: The status word of port p is at index p (0..6). It holds link in bit 0, full duplex in bit 1 and speed in bits 3:2, taken from `poll_stat` of the answer for PHY address p. Answers for addresses 7 and above change no port.
- R6: The change flag of port p (bit p of the flag register at index 9) is set when the polled link bit differs from the stored one. A change of speed or duplex alone sets no flag.
- R7: Writing to index 9 clears exactly the flags written as 1. Writing zeros leaves the flags unchanged.
- R8: When a new change and a clear write hit the same flag in the same cycle, the flag ends set.
- R9: The mask is at index 10. `irq` is high exactly when some flag is set whose mask bit is 0.
- R10: `carrier_up` is high when any of ports 0 to 5 has link. Port 6, the CPU port, is not counted.
- R11: Writes to the port status indices have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 4 | Register write index |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_idx | input | 4 | Register read index |
| reg_rd_data | output | 32 | Register read data, combinational |
| poll_req | output | 1 | Poll request to the management-bus engine |
| poll_addr | output | 5 | PHY address of the pending request |
| poll_ack | input | 1 | Answer valid for the pending request |
| poll_stat | input | 4 | Answer: speed[3:2], duplex[1], link[0] |
| poll_preamble | output | 1 | Preamble enable for the engine |
| poll_clk_div | output | 6 | Clock divider setting for the engine |
| irq | output | 1 | Port change interrupt |
| carrier_up | output | 1 | Any non-CPU port has link |

## Verification
The assertions assume that the engine asserts `poll_ack` only while `poll_req` is high, for a single cycle, and with the status for `poll_addr`. The bench's responder follows this rule. It only acknowledges a request already seen at a falling edge, and it drops the acknowledge on the next falling edge. The window check assumes that software does not move the window bounds in the same cycle that a request starts. The bench therefore changes the window only while polling is disabled. When it disables polling, it keeps the old bounds.

// File: rtl/plm_pkg.sv
package plm_pkg;
    localparam int PHY_AW    = 5;
    localparam int CLK_DIV_W = 6;
    localparam int IDX_W     = 4;
    localparam int DATA_W    = 32;

    localparam logic [IDX_W-1:0] IDX_CFG = 4'd8;
    localparam logic [IDX_W-1:0] IDX_ISR = 4'd9;
    localparam logic [IDX_W-1:0] IDX_IMR = 4'd10;

    typedef struct packed {
        logic [1:0] speed;
        logic       duplex;
        logic       link;
    } port_stat_t;

    typedef struct packed {
        logic                 enable;
        logic                 preamble;
        logic [CLK_DIV_W-1:0] clk_div;
        logic [PHY_AW-1:0]    hi;
        logic [PHY_AW-1:0]    lo;
    } poll_cfg_t;

    function automatic poll_cfg_t cfg_unpack(input logic [DATA_W-1:0] w);
        poll_cfg_t c;
        c.enable   = w[31];
        c.preamble = w[30];
        c.clk_div  = w[29:24];
        c.hi       = w[12:8];
        c.lo       = w[4:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_pack(input poll_cfg_t c);
        return {c.enable, c.preamble, c.clk_div, 11'b0, c.hi, 3'b0, c.lo};
    endfunction

    function automatic logic window_ok(input poll_cfg_t c);
        return c.enable && (c.lo <= c.hi);
    endfunction
endpackage

// File: rtl/plm_poll_seq.sv
module plm_poll_seq
    import plm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  poll_cfg_t         cfg,
    input  logic              ack,
    output logic              req,
    output logic [PHY_AW-1:0] addr
);
    logic [PHY_AW-1:0] nxt_q;
    logic              nxt_in_win;

    assign nxt_in_win = (nxt_q >= cfg.lo) && (nxt_q <= cfg.hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            req   <= 1'b0;
            addr  <= '0;
            nxt_q <= '0;
        end else if (req) begin
            if (ack) begin
                req   <= 1'b0;
                nxt_q <= (addr >= cfg.hi) ? cfg.lo : addr + 1'b1;
            end
        end else if (window_ok(cfg)) begin
            req  <= 1'b1;
            addr <= nxt_in_win ? nxt_q : cfg.lo;
        end
    end
endmodule

// File: rtl/plm_port_bank.sv
module plm_port_bank
    import plm_pkg::*;
#(
    parameter int NUM_PORTS = 7
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         upd_valid,
    input  logic [PHY_AW-1:0]            upd_addr,
    input  port_stat_t                   upd_stat,
    output port_stat_t [NUM_PORTS-1:0]   stat,
    output logic [NUM_PORTS-1:0]         change
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit;
        assign hit       = upd_valid && (upd_addr == PHY_AW'(p));
        assign change[p] = hit && (upd_stat.link != stat[p].link);

        always_ff @(posedge clk) begin
            if (rst)      stat[p] <= '0;
            else if (hit) stat[p] <= upd_stat;
        end
    end
endmodule

// File: rtl/plm_irq_ctrl.sv
module plm_irq_ctrl #(
    parameter int NUM_PORTS = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] change,
    input  logic                 clr_we,
    input  logic [NUM_PORTS-1:0] clr_bits,
    input  logic                 mask_we,
    input  logic [NUM_PORTS-1:0] mask_bits,
    output logic [NUM_PORTS-1:0] isr,
    output logic [NUM_PORTS-1:0] imr,
    output logic                 irq
);
    logic [NUM_PORTS-1:0] clr_eff;
    assign clr_eff = clr_we ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            isr <= '0;
            imr <= '1;
        end else begin
            isr <= (isr & ~clr_eff) | change;
            if (mask_we) imr <= mask_bits;
        end
    end

    assign irq = |(isr & ~imr);
endmodule

// File: rtl/phy_link_monitor.sv
module phy_link_monitor
    import plm_pkg::*;
#(
    parameter int NUM_PORTS = 7,
    parameter int CPU_PORT  = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr_en,
    input  logic [3:0]           reg_wr_idx,
    input  logic [31:0]          reg_wr_data,
    input  logic [3:0]           reg_rd_idx,
    output logic [31:0]          reg_rd_data,
    output logic                 poll_req,
    output logic [4:0]           poll_addr,
    input  logic                 poll_ack,
    input  logic [3:0]           poll_stat,
    output logic                 poll_preamble,
    output logic [5:0]           poll_clk_div,
    output logic                 irq,
    output logic                 carrier_up
);
    localparam int STAT_W = $bits(port_stat_t);

    poll_cfg_t                  cfg_q;
    port_stat_t [NUM_PORTS-1:0] stat;
    logic [NUM_PORTS-1:0]       change;
    logic [NUM_PORTS-1:0]       isr_q;
    logic [NUM_PORTS-1:0]       imr_q;
    logic [NUM_PORTS-1:0]       link_vec;
    logic                       rsp_valid;

    always_ff @(posedge clk) begin
        if (rst)                                     cfg_q <= '0;
        else if (reg_wr_en && reg_wr_idx == IDX_CFG) cfg_q <= cfg_unpack(reg_wr_data);
    end

    assign poll_preamble = cfg_q.preamble;
    assign poll_clk_div  = cfg_q.clk_div;

    plm_poll_seq i_seq (
        .clk  (clk),
        .rst  (rst),
        .cfg  (cfg_q),
        .ack  (poll_ack),
        .req  (poll_req),
        .addr (poll_addr)
    );

    assign rsp_valid = poll_req && poll_ack;

    plm_port_bank #(.NUM_PORTS(NUM_PORTS)) i_bank (
        .clk       (clk),
        .rst       (rst),
        .upd_valid (rsp_valid),
        .upd_addr  (poll_addr),
        .upd_stat  (port_stat_t'(poll_stat)),
        .stat      (stat),
        .change    (change)
    );

    plm_irq_ctrl #(.NUM_PORTS(NUM_PORTS)) i_irq (
        .clk       (clk),
        .rst       (rst),
        .change    (change),
        .clr_we    (reg_wr_en && reg_wr_idx == IDX_ISR),
        .clr_bits  (reg_wr_data[NUM_PORTS-1:0]),
        .mask_we   (reg_wr_en && reg_wr_idx == IDX_IMR),
        .mask_bits (reg_wr_data[NUM_PORTS-1:0]),
        .isr       (isr_q),
        .imr       (imr_q),
        .irq       (irq)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_link
        if (p < CPU_PORT) begin : g_edge
            assign link_vec[p] = stat[p].link;
        end else begin : g_cpu
            assign link_vec[p] = 1'b0;
        end
    end
    assign carrier_up = |link_vec;

    always_comb begin
        reg_rd_data = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (reg_rd_idx == IDX_W'(p)) reg_rd_data = {{(DATA_W-STAT_W){1'b0}}, stat[p]};
        end
        case (reg_rd_idx)
            IDX_CFG: reg_rd_data = cfg_pack(cfg_q);
            IDX_ISR: reg_rd_data = {{(DATA_W-NUM_PORTS){1'b0}}, isr_q};
            IDX_IMR: reg_rd_data = {{(DATA_W-NUM_PORTS){1'b0}}, imr_q};
            default: ;
        endcase
    end
endmodule

// File: rtl/plm_checker.sv
module plm_checker
    import plm_pkg::*;
#(
    parameter int NUM_PORTS = 7
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 poll_req,
    input logic [4:0]           poll_addr,
    input logic                 poll_ack,
    input logic                 reg_wr_en,
    input logic                 irq,
    input logic                 carrier_up,
    input poll_cfg_t            cfg_q,
    input logic [NUM_PORTS-1:0] isr_q
);
    // R3: a new request starts inside the window that was programmed
    assert_window_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(poll_req) |-> (poll_addr >= $past(cfg_q.lo)) && (poll_addr <= $past(cfg_q.hi)));

    // R3: an unanswered request stays up with a steady address
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (poll_req && !poll_ack) |=> (poll_req && $stable(poll_addr)));

    // R4: while idle with polling off or with an empty window, no request starts
    assert_halt_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(!window_ok(cfg_q)) && $past(!poll_req)) |-> !poll_req);

    // R6: a flag only rises after an answer for that port's address
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_src
        assert_change_source_R6: assert property (@(posedge clk) disable iff (rst)
            $rose(isr_q[p]) |-> $past(poll_req && poll_ack && poll_addr == 5'(p)));
    end

    // R9: the interrupt only rises after an answer or a register write
    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(poll_ack) || $past(reg_wr_en)));

    // R10: carrier only comes up after an answer
    assert_carrier_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(carrier_up) |-> $past(poll_ack));
endmodule

bind phy_link_monitor plm_checker #(.NUM_PORTS(NUM_PORTS)) i_plm_checker (
    .clk        (clk),
    .rst        (rst),
    .poll_req   (poll_req),
    .poll_addr  (poll_addr),
    .poll_ack   (poll_ack),
    .reg_wr_en  (reg_wr_en),
    .irq        (irq),
    .carrier_up (carrier_up),
    .cfg_q      (cfg_q),
    .isr_q      (isr_q)
);

// File: tb/test_phy_link_monitor.sv
module test_phy_link_monitor;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_wr_idx = '0;
    logic [31:0] reg_wr_data = '0;
    logic [3:0]  reg_rd_idx = '0;
    logic [31:0] reg_rd_data;
    logic        poll_req;
    logic [4:0]  poll_addr;
    logic        poll_ack = 1'b0;
    logic [3:0]  poll_stat = '0;
    logic        poll_preamble;
    logic [5:0]  poll_clk_div;
    logic        irq;
    logic        carrier_up;

    int   n_tests = 0;
    int   n_fail  = 0;
    logic resp_en = 1'b1;
    logic [3:0] model [32];
    int   log_a [64];
    int   log_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_link_monitor i_phy_link_monitor (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
        .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
        .poll_req(poll_req), .poll_addr(poll_addr), .poll_ack(poll_ack), .poll_stat(poll_stat),
        .poll_preamble(poll_preamble), .poll_clk_div(poll_clk_div),
        .irq(irq), .carrier_up(carrier_up)
    );

    // Management-bus engine model: answers a seen request one half cycle later
    initial begin
        forever begin
            @(negedge clk);
            if (resp_en) begin
                if (poll_ack) begin
                    poll_ack = 1'b0;
                end else if (poll_req) begin
                    poll_ack  = 1'b1;
                    poll_stat = model[poll_addr];
                    if (log_n < 64) log_a[log_n] = int'(poll_addr);
                    log_n++;
                end
            end
        end
    end

    task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, got, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] idx, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_idx = idx; reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] idx, output logic [31:0] data);
        @(negedge clk);
        reg_rd_idx = idx;
        #1;
        data = reg_rd_data;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic test_reset();
        logic [31:0] d;
        for (int p = 0; p < 7; p++) begin
            reg_read(4'(p), d);
            check("R1", "status after reset", d, 32'h0);
        end
        reg_read(4'd8, d);  check("R1", "config after reset", d, 32'h0);
        reg_read(4'd9, d);  check("R1", "flags after reset", d, 32'h0);
        reg_read(4'd10, d); check("R1", "mask after reset", d, 32'h7f);
        check("R1", "req/irq/carrier after reset", {poll_req, irq, carrier_up}, 3'b000);
    endtask

    task automatic test_config();
        logic [31:0] d;
        reg_write(4'd8, 32'h7F1F_1F1F);
        reg_read(4'd8, d);
        check("R2", "config readback", d, 32'h7F00_1F1F);
        check("R2", "preamble out", poll_preamble, 1'b1);
        check("R2", "clk div out", poll_clk_div, 6'h3F);
        log_n = 0;
        wait_cycles(10);
        check("R4", "no poll while disabled", log_n + int'(poll_req), 0);
        reg_write(4'd8, 32'h0);
    endtask

    task automatic test_window();
        log_n = 0;
        reg_write(4'd8, 32'h8000_0402);
        wait_cycles(20);
        check("R3", "enough polls", 32'(log_n >= 6), 1);
        for (int i = 0; i < 6; i++)
            check("R3", "poll order", log_a[i], 2 + (i % 3));
        reg_write(4'd8, 32'h0000_0402);
        wait_cycles(5);
    endtask

    task automatic test_empty_window();
        reg_write(4'd8, 32'h8000_0205);
        log_n = 0;
        wait_cycles(20);
        check("R4", "no poll when lowest above highest", log_n + int'(poll_req), 0);
        reg_write(4'd8, 32'h0000_0205);
    endtask

    task automatic test_link_up();
        logic [31:0] d;
        model[1] = 4'hF;
        reg_write(4'd10, 32'h0);
        reg_write(4'd8, 32'h8000_0600);
        wait_cycles(40);
        reg_read(4'd1, d); check("R5", "port1 status word", d, 32'hF);
        reg_read(4'd0, d); check("R5", "port0 status word", d, 32'h0);
        reg_read(4'd9, d); check("R6", "flag on link up", d, 32'h02);
        check("R9", "irq unmasked", irq, 1'b1);
        check("R10", "carrier with port1", carrier_up, 1'b1);
    endtask

    task automatic test_speed_only();
        logic [31:0] d;
        reg_write(4'd9, 32'h02);
        reg_read(4'd9, d); check("R7", "flag cleared", d, 32'h0);
        check("R9", "irq after clear", irq, 1'b0);
        model[1] = 4'h3;
        wait_cycles(40);
        reg_read(4'd1, d); check("R5", "port1 speed update", d, 32'h3);
        reg_read(4'd9, d); check("R6", "no flag on speed change", d, 32'h0);
    endtask

    task automatic test_mask_and_cpu();
        logic [31:0] d;
        reg_write(4'd10, 32'h40);
        model[6] = 4'h1;
        wait_cycles(40);
        reg_read(4'd9, d); check("R6", "port6 flag", d, 32'h40);
        check("R9", "masked source blocks irq", irq, 1'b0);
        check("R10", "carrier still up", carrier_up, 1'b1);
        model[1] = 4'h0;
        wait_cycles(40);
        reg_read(4'd9, d); check("R6", "port1 down flag", d, 32'h42);
        check("R9", "unmasked source raises irq", irq, 1'b1);
        check("R10", "CPU port does not give carrier", carrier_up, 1'b0);
        reg_write(4'd9, 32'h0);
        reg_read(4'd9, d); check("R7", "zero write keeps flags", d, 32'h42);
    endtask

    task automatic test_high_addresses();
        logic [31:0] d;
        reg_write(4'd8, 32'h0000_0600);
        wait_cycles(5);
        reg_write(4'd9, 32'h7F);
        for (int a = 7; a <= 9; a++) model[a] = 4'hF;
        log_n = 0;
        reg_write(4'd8, 32'h8000_0907);
        wait_cycles(30);
        check("R3", "high window polled", 32'(log_n > 0 && log_a[0] == 7), 1);
        reg_read(4'd9, d); check("R5", "no flag from addresses 7..9", d, 32'h0);
        reg_read(4'd6, d); check("R5", "port6 unchanged", d, 32'h1);
        reg_write(4'd8, 32'h0000_0907);
        wait_cycles(5);
    endtask

    task automatic test_readonly();
        logic [31:0] d;
        reg_write(4'd0, 32'hF);
        reg_read(4'd0, d); check("R11", "status 0 not writable", d, 32'h0);
        reg_write(4'd6, 32'h0);
        reg_read(4'd6, d); check("R11", "status 6 not writable", d, 32'h1);
    endtask

    task automatic test_change_wins();
        logic [31:0] d;
        resp_en = 1'b0;
        reg_write(4'd8, 32'h8000_0303);
        @(negedge clk);
        while (!poll_req) @(negedge clk);
        poll_ack = 1'b1; poll_stat = 4'h1;
        reg_wr_en = 1'b1; reg_wr_idx = 4'd9; reg_wr_data = 32'h08;
        @(negedge clk);
        poll_ack = 1'b0; reg_wr_en = 1'b0;
        reg_read(4'd9, d); check("R8", "change beats clear", d, 32'h08);
        reg_read(4'd3, d); check("R5", "port3 status", d, 32'h1);
        model[3] = 4'h1;
        reg_write(4'd8, 32'h0000_0303);
        resp_en = 1'b1;
        wait_cycles(10);
        reg_write(4'd9, 32'h08);
        reg_read(4'd9, d); check("R7", "clear after race", d, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 32; a++) model[a] = 4'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_config();
        test_window();
        test_empty_window();
        test_link_up();
        test_speed_only();
        test_mask_and_cpu();
        test_high_addresses();
        test_readonly();
        test_change_wins();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule